// File: doc/BRIEF.md
# Multi-Lane Vector Add Unit

This block executes element-wise integer additions on vector registers, spread over several parallel lanes. Each lane keeps its own slice of every vector register: element n lives in lane n mod 4, at slot n/4 of that lane's storage. Every lane has a private, fully pipelined adder. Because element n of one source only ever pairs with element n of the other source, no data crosses between lanes.

An operation is issued with an opcode, a destination register, one or two source registers, a scalar operand and a vector length. There are two forms. The vector-vector form adds two registers element by element. The vector-scalar form adds one scalar, broadcast to every lane, to each element of a register. The sequencer sends one group of four elements per cycle into the lanes until the vector length is covered. In the last group, the lanes past the vector length stay idle. Results come out of the lane pipelines and are written back. A busy flag covers the whole operation, and a single-cycle done pulse marks the point where the final element has been written.

An element-wide load port fills the register slices, and a combinational read port returns any element. Both serve the surrounding datapath. The lane count is a power of two, at least two.

Top module: `vau_top`

## Requirements
- R1: An element written through the load port (`ld_reg`, `ld_idx`) while the unit is idle is returned by the read port for the same register and element index on the following cycle.
- R2: With `issue_op` = 0 (vector-vector), destination element n becomes source-1 element n plus source-2 element n, for every n below the vector length.
- R3: With `issue_op` = 1 (vector-scalar), destination element n becomes source-1 element n plus `issue_scalar`, for every n below the vector length.
- R4: Sums wrap modulo 2^64.
- R5: Destination elements at or above the vector length keep their old values, including the unused lanes of a partial final group.
- R6: `busy` rises on the edge that accepts an issue and stays high for exactly ceil(VL/4) + 6 cycles. `done` is high for exactly one cycle, beginning on the edge where `busy` falls, and by that cycle every result is readable.
- R7: `issue_valid` is ignored while `busy` is high.
- R8: `ld_en` is ignored while `busy` is high.
- R9: A vector length of 0 writes nothing, and `busy` is held for 6 cycles before `done`.
- R10: A vector length above 64 is treated as 64.
- R11: The destination may equal a source. Every element is computed from the source's value as it was before the operation.
- R12: Reset clears `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Request a new operation (taken when not busy) |
| issue_op | input | 1 | 0 = vector plus vector, 1 = vector plus scalar |
| issue_vd | input | 3 | Destination register |
| issue_vs1 | input | 3 | First source register |
| issue_vs2 | input | 3 | Second source register (vector-vector only) |
| issue_scalar | input | 64 | Scalar operand broadcast to all lanes |
| issue_vl | input | 8 | Vector length; values above 64 are clamped |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Element write strobe (idle only) |
| ld_reg | input | 3 | Register of the element write |
| ld_idx | input | 6 | Element index of the element write |
| ld_data | input | 64 | Element write data |
| rd_reg | input | 3 | Register of the element read |
| rd_idx | input | 6 | Element index of the element read |
| rd_data | output | 64 | Element read data (combinational) |

## Verification
The hardest cases to reach from the ports are the ones where the unit is already busy and another request arrives: a second issue, or an element load that would collide with write-back. The stimulus reaches them by holding `issue_valid` high and pulsing `ld_en` in the cycles right after an operation has been accepted. It then reads back the register the rejected issue named and the element the rejected load targeted. Partial final groups (lengths 13 and 10) and the zero and oversized lengths are issued deliberately. A behavioural model in the bench tracks `busy`, `done` and every register element on every clock.

// File: rtl/vau_pkg.sv
package vau_pkg;

    // Operation form selected by issue_op
    typedef enum logic {
        VAU_ADD_VV = 1'b0,
        VAU_ADD_VS = 1'b1
    } vau_op_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } vau_seq_e;

endpackage

// File: rtl/vau_lane_rf.sv
// One lane's slice of the vector register file: one write port and three
// combinational read ports (two operands plus the external element read).
module vau_lane_rf #(
    parameter int DATA_W = 64,
    parameter int REG_W  = 3,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_W-1:0]  a_reg,
    input  logic [SLOT_W-1:0] a_slot,
    output logic [DATA_W-1:0] a_data,
    input  logic [REG_W-1:0]  b_reg,
    input  logic [SLOT_W-1:0] b_slot,
    output logic [DATA_W-1:0] b_data,
    input  logic [REG_W-1:0]  c_reg,
    input  logic [SLOT_W-1:0] c_slot,
    output logic [DATA_W-1:0] c_data
);

    localparam int ENTRIES = 2 ** (REG_W + SLOT_W);

    // Register storage carries no reset; contents are defined by loads.
    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_reg, wr_slot}] <= wr_data;
        end
    end

    assign a_data = mem_q[{a_reg, a_slot}];
    assign b_data = mem_q[{b_reg, b_slot}];
    assign c_data = mem_q[{c_reg, c_slot}];

endmodule

// File: rtl/vau_lane_add.sv
// Fully pipelined lane adder. The sum is formed in the first stage and then
// travels with its destination tag through the remaining stages.
module vau_lane_add #(
    parameter int DATA_W  = 64,
    parameter int ADD_LAT = 6,
    parameter int REG_W   = 3,
    parameter int SLOT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [REG_W-1:0]  in_reg,
    input  logic [SLOT_W-1:0] in_slot,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic [REG_W-1:0]  wb_reg,
    output logic [SLOT_W-1:0] wb_slot
);

    typedef struct packed {
        logic              vld;
        logic [REG_W-1:0]  rg;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] sum;
    } stage_t;

    stage_t [ADD_LAT-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d[0].vld  = in_valid;
        pipe_d[0].rg   = in_reg;
        pipe_d[0].slot = in_slot;
        pipe_d[0].sum  = in_a + in_b;   // wraps at DATA_W bits
        for (int s = 1; s < ADD_LAT; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign wb_valid = pipe_q[ADD_LAT-1].vld;
    assign wb_data  = pipe_q[ADD_LAT-1].sum;
    assign wb_reg   = pipe_q[ADD_LAT-1].rg;
    assign wb_slot  = pipe_q[ADD_LAT-1].slot;

endmodule

// File: rtl/vau_seq.sv
// Issue sequencer: accepts an operation, sends one element group per cycle,
// then waits for the lane pipelines to drain before pulsing done.
module vau_seq
    import vau_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int MAX_VL    = 64,
    parameter int DATA_W    = 64,
    parameter int ADD_LAT   = 6,
    parameter int REG_W     = 3,
    parameter int SLOT_W    = 4,
    parameter int VL_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic                 issue_op,
    input  logic [REG_W-1:0]     issue_vd,
    input  logic [REG_W-1:0]     issue_vs1,
    input  logic [REG_W-1:0]     issue_vs2,
    input  logic [DATA_W-1:0]    issue_scalar,
    input  logic [VL_W-1:0]      issue_vl,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_LANES-1:0] disp_mask,
    output logic [SLOT_W-1:0]    disp_slot,
    output logic                 op_scalar,
    output logic [REG_W-1:0]     cur_vd,
    output logic [REG_W-1:0]     cur_vs1,
    output logic [REG_W-1:0]     cur_vs2,
    output logic [DATA_W-1:0]    cur_scalar
);

    localparam int LANE_SH = $clog2(NUM_LANES);
    localparam int TAIL_W  = LANE_SH + 1;
    localparam int CNT_W   = $clog2(ADD_LAT + 1);

    typedef struct packed {
        vau_seq_e          st;
        logic [SLOT_W-1:0] grp;     // group being sent this cycle
        logic [SLOT_W-1:0] last;    // index of the final group
        logic [TAIL_W-1:0] tail;    // active lanes in the final group
        logic [CNT_W-1:0]  drain;   // cycles left until the last write
        logic              done;
        vau_op_e           op;
        logic [REG_W-1:0]  vd;
        logic [REG_W-1:0]  vs1;
        logic [REG_W-1:0]  vs2;
        logic [DATA_W-1:0] scalar;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [VL_W-1:0] vl_eff;
    logic [VL_W-1:0] vl_m1;
    logic [VL_W-1:0] tail_full;

    always_comb begin
        vl_eff    = (issue_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : issue_vl;
        vl_m1     = vl_eff - 1'b1;
        tail_full = vl_eff - ((vl_m1 >> LANE_SH) << LANE_SH);

        seq_d      = seq_q;
        seq_d.done = 1'b0;

        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (issue_valid) begin
                    seq_d.op     = vau_op_e'(issue_op);
                    seq_d.vd     = issue_vd;
                    seq_d.vs1    = issue_vs1;
                    seq_d.vs2    = issue_vs2;
                    seq_d.scalar = issue_scalar;
                    seq_d.grp    = '0;
                    if (vl_eff == '0) begin
                        seq_d.st    = SEQ_DRAIN;
                        seq_d.drain = CNT_W'(ADD_LAT - 1);
                    end else begin
                        seq_d.st   = SEQ_RUN;
                        seq_d.last = SLOT_W'(vl_m1 >> LANE_SH);
                        seq_d.tail = TAIL_W'(tail_full);
                    end
                end
            end
            SEQ_RUN: begin
                if (seq_q.grp == seq_q.last) begin
                    seq_d.st    = SEQ_DRAIN;
                    seq_d.drain = CNT_W'(ADD_LAT - 1);
                end else begin
                    seq_d.grp = seq_q.grp + 1'b1;
                end
            end
            SEQ_DRAIN: begin
                if (seq_q.drain == '0) begin
                    seq_d.st   = SEQ_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.drain = seq_q.drain - 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Lane enables: full groups use every lane, the final group only the
    // lanes below the vector length.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            disp_mask[l] = (seq_q.st == SEQ_RUN) &&
                           ((seq_q.grp != seq_q.last) ||
                            (TAIL_W'(l) < seq_q.tail));
        end
    end

    assign busy       = (seq_q.st != SEQ_IDLE);
    assign done       = seq_q.done;
    assign disp_slot  = seq_q.grp;
    assign op_scalar  = (seq_q.op == VAU_ADD_VS);
    assign cur_vd     = seq_q.vd;
    assign cur_vs1    = seq_q.vs1;
    assign cur_vs2    = seq_q.vs2;
    assign cur_scalar = seq_q.scalar;

endmodule

// File: rtl/vau_top.sv
// Multi-lane vector add unit: striped register slices, per-lane pipelined
// adders and a shared issue sequencer.
module vau_top #(
    parameter int NUM_LANES = 4,
    parameter int NUM_REGS  = 8,
    parameter int MAX_VL    = 64,
    parameter int DATA_W    = 64,
    parameter int ADD_LAT   = 6,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int IDX_W    = $clog2(MAX_VL),
    localparam int VL_W     = IDX_W + 2,
    localparam int LANE_SH  = $clog2(NUM_LANES),
    localparam int SLOT_W   = IDX_W - LANE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_op,
    input  logic [REG_W-1:0]  issue_vd,
    input  logic [REG_W-1:0]  issue_vs1,
    input  logic [REG_W-1:0]  issue_vs2,
    input  logic [DATA_W-1:0] issue_scalar,
    input  logic [VL_W-1:0]   issue_vl,
    output logic              busy,
    output logic              done,
    input  logic              ld_en,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [REG_W-1:0]  rd_reg,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_LANES-1:0] disp_mask;
    logic [NUM_LANES-1:0] wb_mask;
    logic [SLOT_W-1:0]    disp_slot;
    logic                 op_scalar;
    logic [REG_W-1:0]     cur_vd, cur_vs1, cur_vs2;
    logic [DATA_W-1:0]    cur_scalar;
    logic [DATA_W-1:0]    rd_lane [NUM_LANES];

    logic [LANE_SH-1:0]   ld_lane, rd_lane_sel;
    logic [SLOT_W-1:0]    ld_slot, rd_slot;

    assign ld_lane     = ld_idx[LANE_SH-1:0];
    assign ld_slot     = ld_idx[IDX_W-1:LANE_SH];
    assign rd_lane_sel = rd_idx[LANE_SH-1:0];
    assign rd_slot     = rd_idx[IDX_W-1:LANE_SH];

    vau_seq #(
        .NUM_LANES (NUM_LANES),
        .MAX_VL    (MAX_VL),
        .DATA_W    (DATA_W),
        .ADD_LAT   (ADD_LAT),
        .REG_W     (REG_W),
        .SLOT_W    (SLOT_W),
        .VL_W      (VL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_op     (issue_op),
        .issue_vd     (issue_vd),
        .issue_vs1    (issue_vs1),
        .issue_vs2    (issue_vs2),
        .issue_scalar (issue_scalar),
        .issue_vl     (issue_vl),
        .busy         (busy),
        .done         (done),
        .disp_mask    (disp_mask),
        .disp_slot    (disp_slot),
        .op_scalar    (op_scalar),
        .cur_vd       (cur_vd),
        .cur_vs1      (cur_vs1),
        .cur_vs2      (cur_vs2),
        .cur_scalar   (cur_scalar)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : gen_lane
        logic              ld_hit;
        logic              wb_valid;
        logic [DATA_W-1:0] wb_data;
        logic [REG_W-1:0]  wb_reg;
        logic [SLOT_W-1:0] wb_slot;
        logic [DATA_W-1:0] src_a, src_b, opnd_b;

        // Loads are accepted only while no operation owns the slices.
        assign ld_hit = ld_en && !busy && (ld_lane == LANE_SH'(g));
        assign opnd_b = op_scalar ? cur_scalar : src_b;

        vau_lane_rf #(
            .DATA_W (DATA_W),
            .REG_W  (REG_W),
            .SLOT_W (SLOT_W)
        ) u_rf (
            .clk     (clk),
            .wr_en   (wb_valid || ld_hit),
            .wr_reg  (wb_valid ? wb_reg  : ld_reg),
            .wr_slot (wb_valid ? wb_slot : ld_slot),
            .wr_data (wb_valid ? wb_data : ld_data),
            .a_reg   (cur_vs1),
            .a_slot  (disp_slot),
            .a_data  (src_a),
            .b_reg   (cur_vs2),
            .b_slot  (disp_slot),
            .b_data  (src_b),
            .c_reg   (rd_reg),
            .c_slot  (rd_slot),
            .c_data  (rd_lane[g])
        );

        vau_lane_add #(
            .DATA_W  (DATA_W),
            .ADD_LAT (ADD_LAT),
            .REG_W   (REG_W),
            .SLOT_W  (SLOT_W)
        ) u_add (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (disp_mask[g]),
            .in_a     (src_a),
            .in_b     (opnd_b),
            .in_reg   (cur_vd),
            .in_slot  (disp_slot),
            .wb_valid (wb_valid),
            .wb_data  (wb_data),
            .wb_reg   (wb_reg),
            .wb_slot  (wb_slot)
        );

        assign wb_mask[g] = wb_valid;
    end

    assign rd_data = rd_lane[rd_lane_sel];

endmodule

// File: rtl/vau_chk.sv
module vau_chk #(
    parameter int NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic [NUM_LANES-1:0] disp_mask,
    input logic [NUM_LANES-1:0] wb_mask
);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    idle_no_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (disp_mask == '0));

    // R8
    wb_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_mask != '0) |-> busy);

    // R5
    lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mask & (disp_mask + 1'b1)) == '0);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

endmodule

bind vau_top vau_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .disp_mask (disp_mask),
    .wb_mask   (wb_mask)
);

// File: tb/tb_vau_top.sv
`timescale 1ns/1ps
module tb_vau_top;

    localparam int REGS = 8;
    localparam int MVL  = 64;
    localparam int LAT  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_op = 1'b0;
    logic [2:0]  issue_vd = '0, issue_vs1 = '0, issue_vs2 = '0;
    logic [63:0] issue_scalar = '0;
    logic [7:0]  issue_vl = '0;
    logic        busy, done;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [5:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;

    vau_top dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
        .issue_scalar(issue_scalar), .issue_vl(issue_vl),
        .busy(busy), .done(done),
        .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit mon_on = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int r, input int i);
        return 64'h0123_4567_89AB_CDEF * 64'(r + 1) + 64'(i) * 64'h0000_0001_0000_0001;
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [63:0] mdl  [REGS][MVL];
    bit          mval [REGS][MVL];
    logic [63:0] pend [MVL];
    bit          pend_we [MVL];
    int          pend_vd = 0;
    int          m_cnt = 0;
    bit          m_done = 0;
    int          vle = 0;

    initial begin
        for (int r = 0; r < REGS; r++)
            for (int i = 0; i < MVL; i++) mval[r][i] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_done = 0;
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    for (int n = 0; n < MVL; n++)
                        if (pend_we[n]) mdl[pend_vd][n] = pend[n];
                    m_done = 1;
                end
            end else begin
                if (ld_en) begin
                    mdl[ld_reg][ld_idx]  = ld_data;
                    mval[ld_reg][ld_idx] = 1;
                end
                if (issue_valid) begin
                    vle = (int'(issue_vl) > MVL) ? MVL : int'(issue_vl);
                    for (int n = 0; n < MVL; n++) begin
                        pend_we[n] = (n < vle);
                        if (n < vle)
                            pend[n] = mdl[issue_vs1][n] +
                                      (issue_op ? issue_scalar : mdl[issue_vs2][n]);
                    end
                    pend_vd = int'(issue_vd);
                    m_cnt   = (vle + 3) / 4 + LAT;
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_on && !finished) begin
            chk("R6 busy vs model", {63'b0, busy}, {63'b0, (m_cnt > 0)});
            chk("R6 done vs model", {63'b0, done}, {63'b0, m_done});
            if (m_cnt == 0 && mval[rd_reg][rd_idx])
                chk("R1 read port vs model", rd_data, mdl[rd_reg][rd_idx]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic load_elem(input int r, input int i, input logic [63:0] d);
        @(negedge clk); #2;
        ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = d;
        @(negedge clk); #2;
        ld_en = 1'b0;
    endtask

    task automatic read_elem(input int r, input int i, output logic [63:0] d);
        @(negedge clk); #2;
        rd_reg = 3'(r); rd_idx = 6'(i);
        #1 d = rd_data;
    endtask

    task automatic run_op(input bit op, input int vd, input int vs1, input int vs2,
                          input logic [63:0] sc, input int vl, output int nbusy);
        @(negedge clk); #2;
        issue_valid = 1'b1; issue_op = op; issue_vd = 3'(vd);
        issue_vs1 = 3'(vs1); issue_vs2 = 3'(vs2); issue_scalar = sc; issue_vl = 8'(vl);
        @(negedge clk);
        nbusy = busy ? 1 : 0;
        #2 issue_valid = 1'b0;
        while (1) begin
            @(negedge clk);
            if (done) break;
            if (busy) nbusy++;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL R6 watchdog: got still running, expected completion");
            summary();
            $finish;
        end
    end

    logic [63:0] v;
    int nb;

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy in reset", {63'b0, busy}, 64'd0);
        chk("R12 done in reset", {63'b0, done}, 64'd0);
        #2 rst_n = 1'b1;
        mon_on = 1;

        for (int r = 0; r < REGS; r++)
            for (int i = 0; i < MVL; i++)
                load_elem(r, i, (r == 5) ? 64'hFFFF_FFFF_FFFF_FFFF : pat(r, i));

        // R1: striped load/read at several indices
        foreach (v[k]) begin end
        read_elem(0, 0,  v); chk("R1 v0[0]",  v, pat(0, 0));
        read_elem(0, 5,  v); chk("R1 v0[5]",  v, pat(0, 5));
        read_elem(2, 63, v); chk("R1 v2[63]", v, pat(2, 63));

        // R2: full-length vector plus vector
        run_op(1'b0, 3, 1, 2, 64'h0, 64, nb);
        chk("R6 busy cycles vl=64", 64'(nb), 64'd22);
        for (int i = 0; i < MVL; i++) begin
            read_elem(3, i, v); chk("R2 v3=v1+v2", v, pat(1, i) + pat(2, i));
        end

        // R3/R5: scalar broadcast with partial final group (vl=13)
        run_op(1'b1, 4, 1, 0, 64'h0000_1000_0000_0007, 13, nb);
        chk("R6 busy cycles vl=13", 64'(nb), 64'd10);
        for (int i = 0; i < MVL; i++) begin
            read_elem(4, i, v);
            if (i < 13) chk("R3 v4=v1+scalar", v, pat(1, i) + 64'h0000_1000_0000_0007);
            else        chk("R5 v4 tail untouched", v, pat(4, i));
        end

        // R4: wrap-around
        run_op(1'b1, 5, 5, 0, 64'd2, 8, nb);
        for (int i = 0; i < 12; i++) begin
            read_elem(5, i, v);
            chk("R4 wrap", v, (i < 8) ? 64'd1 : 64'hFFFF_FFFF_FFFF_FFFF);
        end

        // R9: zero length
        run_op(1'b0, 6, 1, 2, 64'h0, 0, nb);
        chk("R9 busy cycles vl=0", 64'(nb), 64'(LAT));
        for (int i = 0; i < 8; i++) begin
            read_elem(6, i, v); chk("R9 v6 unchanged", v, pat(6, i));
        end

        // R7/R8: second issue and a load while busy are ignored
        @(negedge clk); #2;
        issue_valid = 1'b1; issue_op = 1'b0; issue_vd = 3'd3;
        issue_vs1 = 3'd1; issue_vs2 = 3'd2; issue_vl = 8'd64;
        @(negedge clk); #2;
        issue_vd = 3'd6; issue_vs1 = 3'd0; issue_vs2 = 3'd0;
        ld_en = 1'b1; ld_reg = 3'd0; ld_idx = 6'd0; ld_data = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk); #2;
        issue_valid = 1'b0; ld_en = 1'b0;
        while (!done) @(negedge clk);
        read_elem(0, 0, v); chk("R8 load while busy ignored", v, pat(0, 0));
        for (int i = 0; i < MVL; i += 7) begin
            read_elem(6, i, v); chk("R7 issue while busy ignored", v, pat(6, i));
        end

        // R10: oversized length clamps to 64
        run_op(1'b1, 7, 0, 0, 64'd5, 200, nb);
        chk("R10 busy cycles vl=200", 64'(nb), 64'd22);
        for (int i = 0; i < MVL; i++) begin
            read_elem(7, i, v); chk("R10 v7=v0+5", v, pat(0, i) + 64'd5);
        end

        // R11: in-place destination, partial group of two lanes (vl=10)
        run_op(1'b0, 1, 1, 2, 64'h0, 10, nb);
        for (int i = 0; i < 16; i++) begin
            read_elem(1, i, v);
            chk("R11 in-place", v, (i < 10) ? pat(1, i) + pat(2, i) : pat(1, i));
        end

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule